// File: doc/BRIEF.md
# Pointer-Based I2C Register Target

This block is the bus-facing side of a sensor's register file. It listens on a synchronously sampled two-wire bus (SCL and SDA, open-drain), answers to one fixed 7-bit target address and serves an 8-bit register space. It uses one register pointer. The first data byte of each write transaction loads the pointer. Each data byte that is then written or read moves it on by one. The pointer is not reset by a STOP, so a controller can continue a read in a new transaction without sending the address again.

Sixteen-bit quantities are kept coherent. Result fields come from the measurement core. A read of the low byte of a result freezes the upper half, and the next high-byte read returns that frozen half. Threshold fields go to the measurement core. A write to a low byte is parked in one shared holding byte, and both halves are committed together only when a high byte is written. A status byte collects hardware events. Writing a 1 to a flag clears it, and a configuration bit can make a read of the status byte clear every flag.

Top module: `i2c_regptr_if`

Register layout (pointer values): 0x00–0x05 read/write configuration bytes, with reset values 0x00, 0x00, 0x80, 0x04, 0x0C, 0x7F. Bit 7 of byte 0x04 enables clear-on-read. 0x06 and 0x07 are read-only identity bytes. 0x08/0x09 form the lower threshold and 0x0A/0x0B form the upper threshold, low byte first. 0x0C is the status byte. 0x10 + 2·n and 0x11 + 2·n form result channel n, low byte first. All other pointer values are unmapped.

## Requirements
- R1: After reset, pointer values 0x00–0x07 read 0x00, 0x00, 0x80, 0x04, 0x0C, 0x7F, 0xDC, 0x41. Both thresholds and the status byte are zero.
- R2: Only target address 0x39 is acknowledged. A transaction to any other address gets no ACK and changes no register.
- R3: The target drives SDA low for the ACK on the ninth clock of the address byte and of every written byte. It changes its SDA drive only while SCL is low.
- R4: In a write transaction, the first byte after address+W loads the pointer. Each later byte is written at the pointer, the pointer then increments, and `wr_stb_o` pulses for one cycle with the pointer in `wr_addr_o` and the byte in `wr_data_o`.
- R5: In a read transaction, bytes come from successive pointer values. A controller ACK requests another byte, and a NACK ends the transfer.
- R6: The pointer is kept across STOP. A read that sends no pointer byte starts at the last pointer used plus one.
- R7: Reading the low byte of a result channel captures that channel's upper half. The next read of the high byte returns the captured value even if the live result has changed in the meantime.
- R8: A write to a threshold low byte leaves both thresholds unchanged. A write to a threshold high byte loads that threshold with the written high byte and the held low byte in the same cycle.
- R9: When a low byte written at one threshold is followed by a high-byte write to the other threshold, the held low byte goes into the threshold that received the high byte.
- R10: Writing the status byte clears each flag whose data bit is 1. A hardware event on `flag_set_i` in the same cycle as a clear leaves that flag set.
- R11: With bit 7 of byte 0x04 set, reading the status byte returns the flags and then clears all of them. With that bit clear, a read leaves the flags unchanged.
- R12: Writes to the identity bytes are acknowledged and ignored. Reads of unmapped pointer values return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| flag_set_i | input | 8 | Hardware events that set status flags |
| res_i | input | NCH*16 | Live results, channel n at bits [16n+15:16n] |
| wr_stb_o | output | 1 | One-cycle pulse for each register byte written |
| wr_addr_o | output | 8 | Register pointer (the write address during `wr_stb_o`) |
| wr_data_o | output | 8 | Byte written during `wr_stb_o` |
| rd_stb_o | output | 1 | One-cycle pulse when a byte is fetched for reading |
| rd_data_o | output | 8 | Last byte fetched for transmission |
| cfg_o | output | 48 | Configuration bytes, byte k at bits [8k+7:8k] |
| thr_o | output | NTHR*16 | Committed thresholds, threshold n at bits [16n+15:16n] |
| flags_o | output | 8 | Status flags |

## Verification
A hardware event can land in the same clock cycle as a status clear. The clear can come from a written 1 or from a read with clear-on-read enabled. The bench provokes this by watching `wr_stb_o` with `wr_addr_o` at the status byte and pulsing `flag_set_i` on that same cycle. It then judges the result from `flags_o` after the strobe: the event bit must survive, and the other written bits must be cleared. A threshold commit can also coincide with a pending held low byte from another threshold. This case is judged through `thr_o`: the high-byte target must take the held byte and the other threshold must not move.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_AACK,
    PH_WBYTE,
    PH_WACK,
    PH_RBYTE,
    PH_RACK
  } phase_e;

  localparam int          NCFG       = 6;
  localparam logic [7:0]  A_CFG0     = 8'h00;
  localparam logic [7:0]  A_IDA      = 8'h06;
  localparam logic [7:0]  A_IDB      = 8'h07;
  localparam logic [7:0]  A_THR0     = 8'h08;
  localparam logic [7:0]  A_FLAGS    = 8'h0C;
  localparam logic [7:0]  A_CH0      = 8'h10;
  localparam logic [7:0]  IDA_VAL    = 8'hDC;
  localparam logic [7:0]  IDB_VAL    = 8'h41;
  localparam int          RDCLR_BYTE = 4;
  localparam int          RDCLR_BIT  = 7;

  function automatic logic [7:0] cfg_rst(input int idx);
    case (idx)
      2:       cfg_rst = 8'h80;
      3:       cfg_rst = 8'h04;
      4:       cfg_rst = 8'h0C;
      5:       cfg_rst = 8'h7F;
      default: cfg_rst = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_regptr_sync.sv
module i2c_regptr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '1;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o    = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/i2c_regptr_phy.sv
module i2c_regptr_phy
  import i2c_regptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       ptr_ld_o,
  output logic       wr_o,
  output logic       rd_o,
  output logic [7:0] byte_o,
  output logic [7:0] tx_byte_o
);
  logic [1:0] line_s, line_p;
  logic       scl_s, sda_s, scl_p, sda_p;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  i2c_regptr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s),
    .prev_o (line_p)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];
  assign scl_p = line_p[1];
  assign sda_p = line_p[0];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  phase_e     ph_q, ph_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] txb_q, txb_d;
  logic [7:0] byte_q, byte_d;
  logic       rw_q, rw_d;
  logic       ptrph_q, ptrph_d;
  logic       ack_q, ack_d;
  logic       ld_q, ld_d;
  logic       wr_q, wr_d;
  logic       rd_q, rd_d;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    txb_d   = txb_q;
    byte_d  = byte_q;
    rw_d    = rw_q;
    ptrph_d = ptrph_q;
    ack_d   = ack_q;
    ld_d    = 1'b0;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    if (bus_start) begin
      ph_d  = PH_ADDR;
      cnt_d = 4'd0;
    end else if (bus_stop) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_ADDR, PH_WBYTE: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = 4'd0;
            if (ph_q == PH_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                ph_d = PH_AACK;
                rw_d = sh_q[0];
              end else begin
                ph_d = PH_IDLE;
              end
            end else begin
              ph_d   = PH_WACK;
              byte_d = sh_q;
              if (ptrph_q) begin
                ld_d    = 1'b1;
                ptrph_d = 1'b0;
              end else begin
                wr_d = 1'b1;
              end
            end
          end
        end
        PH_AACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw_q) begin
              ph_d  = PH_RBYTE;
              tx_d  = rd_data_i;
              txb_d = rd_data_i;
              rd_d  = 1'b1;
            end else begin
              ph_d    = PH_WBYTE;
              ptrph_d = 1'b1;
            end
          end
        end
        PH_WACK: begin
          if (scl_fall) begin
            ph_d  = PH_WBYTE;
            cnt_d = 4'd0;
          end
        end
        PH_RBYTE: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              ph_d = PH_RACK;
            end else begin
              tx_d  = {tx_q[6:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              ph_d  = PH_RBYTE;
              cnt_d = 4'd0;
              tx_d  = rd_data_i;
              txb_d = rd_data_i;
              rd_d  = 1'b1;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'h00;
      tx_q    <= 8'hFF;
      txb_q   <= 8'h00;
      byte_q  <= 8'h00;
      rw_q    <= 1'b0;
      ptrph_q <= 1'b0;
      ack_q   <= 1'b0;
      ld_q    <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      txb_q   <= txb_d;
      byte_q  <= byte_d;
      rw_q    <= rw_d;
      ptrph_q <= ptrph_d;
      ack_q   <= ack_d;
      ld_q    <= ld_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
    end
  end

  assign sda_oe_o  = (ph_q == PH_AACK) || (ph_q == PH_WACK) ||
                     ((ph_q == PH_RBYTE) && !tx_q[7]);
  assign ptr_ld_o  = ld_q;
  assign wr_o      = wr_q;
  assign rd_o      = rd_q;
  assign byte_o    = byte_q;
  assign tx_byte_o = txb_q;
endmodule

// File: rtl/i2c_regptr_map.sv
module i2c_regptr_map
  import i2c_regptr_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NTHR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_ld_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        byte_i,
  input  logic [7:0]        flag_set_i,
  input  logic [NCH*16-1:0] res_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        ptr_o,
  output logic [NCFG*8-1:0] cfg_o,
  output logic [NTHR*16-1:0] thr_o,
  output logic [7:0]        flags_o
);
  localparam logic [7:0] THR_END = 8'(int'(A_THR0) + 2 * NTHR);

  logic [7:0]  ptr_q, ptr_d;
  logic [7:0]  hold_q;
  logic        hold_en;
  logic [7:0]  flags_q, flags_d, clr_mask;
  logic [7:0]  cfg_w  [NCFG];
  logic [15:0] thr_w  [NTHR];
  logic [7:0]  shad_w [NCH];

  // pointer: load from first write byte, step after every data byte
  always_comb begin
    ptr_d = ptr_q;
    if (ptr_ld_i)          ptr_d = byte_i;
    else if (wr_i || rd_i) ptr_d = ptr_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 8'h00;
    else        ptr_q <= ptr_d;
  end

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      localparam logic [7:0] ADR = 8'(int'(A_CFG0) + g);
      logic [7:0] r_q;
      logic       en;
      assign en = wr_i && (ptr_q == ADR);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  r_q <= cfg_rst(g);
        else if (en) r_q <= byte_i;
      end
      assign cfg_w[g]          = r_q;
      assign cfg_o[g*8 +: 8]   = r_q;
    end
  endgenerate

  // shared low-byte holding latch for all thresholds
  assign hold_en = wr_i && !ptr_q[0] && (ptr_q >= A_THR0) && (ptr_q < THR_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 8'h00;
    else if (hold_en) hold_q <= byte_i;
  end

  generate
    for (genvar g = 0; g < NTHR; g++) begin : g_thr
      localparam logic [7:0] ADR_HI = 8'(int'(A_THR0) + 2 * g + 1);
      logic [15:0] r_q;
      logic        en;
      assign en = wr_i && (ptr_q == ADR_HI);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  r_q <= 16'h0000;
        else if (en) r_q <= {byte_i, hold_q};
      end
      assign thr_w[g]          = r_q;
      assign thr_o[g*16 +: 16] = r_q;
    end
  endgenerate

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [7:0] ADR_LO = 8'(int'(A_CH0) + 2 * g);
      logic [7:0] r_q;
      logic       cap;
      assign cap = rd_i && (ptr_q == ADR_LO);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   r_q <= 8'h00;
        else if (cap) r_q <= res_i[g*16+8 +: 8];
      end
      assign shad_w[g] = r_q;
    end
  endgenerate

  // status: clear by written ones or by read when enabled; events win
  always_comb begin
    clr_mask = 8'h00;
    if (wr_i && ptr_q == A_FLAGS) clr_mask = byte_i;
    if (rd_i && ptr_q == A_FLAGS && cfg_w[RDCLR_BYTE][RDCLR_BIT]) clr_mask = 8'hFF;
    flags_d = (flags_q & ~clr_mask) | flag_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 8'h00;
    else        flags_q <= flags_d;
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NCFG; i++)
      if (ptr_q == 8'(int'(A_CFG0) + i)) rd_data_o = cfg_w[i];
    if (ptr_q == A_IDA)   rd_data_o = IDA_VAL;
    if (ptr_q == A_IDB)   rd_data_o = IDB_VAL;
    for (int i = 0; i < NTHR; i++) begin
      if (ptr_q == 8'(int'(A_THR0) + 2 * i))     rd_data_o = thr_w[i][7:0];
      if (ptr_q == 8'(int'(A_THR0) + 2 * i + 1)) rd_data_o = thr_w[i][15:8];
    end
    if (ptr_q == A_FLAGS) rd_data_o = flags_q;
    for (int i = 0; i < NCH; i++) begin
      if (ptr_q == 8'(int'(A_CH0) + 2 * i))     rd_data_o = res_i[i*16 +: 8];
      if (ptr_q == 8'(int'(A_CH0) + 2 * i + 1)) rd_data_o = shad_w[i];
    end
  end

  assign ptr_o   = ptr_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/i2c_regptr_if.sv
module i2c_regptr_if
  import i2c_regptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39,
  parameter int         NCH      = 4,
  parameter int         NTHR     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [7:0]          flag_set_i,
  input  logic [NCH*16-1:0]   res_i,
  output logic                wr_stb_o,
  output logic [7:0]          wr_addr_o,
  output logic [7:0]          wr_data_o,
  output logic                rd_stb_o,
  output logic [7:0]          rd_data_o,
  output logic [NCFG*8-1:0]   cfg_o,
  output logic [NTHR*16-1:0]  thr_o,
  output logic [7:0]          flags_o
);
  logic       ptr_ld, wr_p, rd_p;
  logic [7:0] byte_w, fetch_w;

  i2c_regptr_phy #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(2)) u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .rd_data_i (fetch_w),
    .sda_oe_o  (sda_oe_o),
    .ptr_ld_o  (ptr_ld),
    .wr_o      (wr_p),
    .rd_o      (rd_p),
    .byte_o    (byte_w),
    .tx_byte_o (rd_data_o)
  );

  i2c_regptr_map #(.NCH(NCH), .NTHR(NTHR)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_ld_i   (ptr_ld),
    .wr_i       (wr_p),
    .rd_i       (rd_p),
    .byte_i     (byte_w),
    .flag_set_i (flag_set_i),
    .res_i      (res_i),
    .rd_data_o  (fetch_w),
    .ptr_o      (wr_addr_o),
    .cfg_o      (cfg_o),
    .thr_o      (thr_o),
    .flags_o    (flags_o)
  );

  assign wr_stb_o  = wr_p;
  assign wr_data_o = byte_w;
  assign rd_stb_o  = rd_p;
endmodule

// File: rtl/i2c_regptr_if_chk.sv
module i2c_regptr_if_chk #(
  parameter int NTHR = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               wr_stb_o,
  input logic [7:0]         wr_addr_o,
  input logic [7:0]         wr_data_o,
  input logic [7:0]         flag_set_i,
  input logic [7:0]         flags_o,
  input logic [NTHR*16-1:0] thr_o
);
  // R3: SDA drive only moves while SCL is low
  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R4: write strobe lasts one cycle
  assert_wr_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R8: a low-byte threshold write commits nothing
  assert_thr_low_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && !wr_addr_o[0] && wr_addr_o >= 8'h08 && wr_addr_o < 8'h0C)
    |=> ($stable(thr_o)));

  // R8: a high-byte write lands in the upper half of its threshold
  assert_thr_high_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && wr_addr_o == 8'h09) |=> (thr_o[15:8] == $past(wr_data_o)));

  // R10: written ones clear flags when no event competes
  assert_flag_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && wr_addr_o == 8'h0C && flag_set_i == 8'h00)
    |=> ((flags_o & $past(wr_data_o)) == 8'h00));

  // R10: an event always sets its flag
  assert_flag_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set_i != 8'h00) |=> ((flags_o & $past(flag_set_i)) == $past(flag_set_i)));
endmodule

bind i2c_regptr_if i2c_regptr_if_chk #(.NTHR(NTHR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .wr_stb_o   (wr_stb_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .flag_set_i (flag_set_i),
  .flags_o    (flags_o),
  .thr_o      (thr_o)
);

// File: tb/i2c_regptr_if_tb.sv
module i2c_regptr_if_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 8;
  localparam int         NCH        = 4;
  localparam int         NTHR       = 2;
  localparam int         WD_CYCLES  = 150000;
  localparam logic [6:0] TGT        = 7'h39;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tb_scl = 1'b1;
  logic              tb_sda = 1'b1;
  logic              sda_line;
  logic              sda_oe;
  logic [7:0]        flag_set = 8'h00;
  logic [NCH*16-1:0] res = '0;
  logic              wr_stb, rd_stb;
  logic [7:0]        wr_addr, wr_data, rd_data, flags;
  logic [47:0]       cfg;
  logic [NTHR*16-1:0] thr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] last_wa = 8'h00;
  logic [7:0] last_wd = 8'h00;
  logic [7:0] rbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = tb_sda & ~sda_oe;

  i2c_regptr_if #(.DEV_ADDR(TGT), .NCH(NCH), .NTHR(NTHR)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (tb_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .flag_set_i (flag_set),
    .res_i      (res),
    .wr_stb_o   (wr_stb),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_stb_o   (rd_stb),
    .rd_data_o  (rd_data),
    .cfg_o      (cfg),
    .thr_o      (thr),
    .flags_o    (flags)
  );

  always @(negedge clk) if (wr_stb) begin
    last_wa <= wr_addr;
    last_wd <= wr_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_sda = 1'b1; wq();
    tb_scl = 1'b1; wq();
    tb_sda = 1'b0; wq();
    tb_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    tb_sda = 1'b0; wq();
    tb_scl = 1'b1; wq();
    tb_sda = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; wq();
      tb_scl = 1'b1; wq(); wq();
      tb_scl = 1'b0; wq();
    end
    tb_sda = 1'b1; wq();
    tb_scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq();
    tb_scl = 1'b0; wq();
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tb_sda = 1'b1; wq();
      tb_scl = 1'b1; wq();
      b[i] = sda_line;
      wq();
      tb_scl = 1'b0; wq();
    end
    tb_sda = give_ack ? 1'b0 : 1'b1; wq();
    tb_scl = 1'b1; wq(); wq();
    tb_scl = 1'b0; wq();
    tb_sda = 1'b1;
  endtask

  task automatic wr_bytes(input logic [7:0] ptr, input int n,
                          input logic [7:0] d0, input logic [7:0] d1);
    logic a;
    bus_start();
    send({TGT, 1'b0}, a); chk("R3 ack address+W", a, 1'b1);
    send(ptr, a);         chk("R3 ack pointer byte", a, 1'b1);
    send(d0, a);          chk("R3 ack data byte", a, 1'b1);
    if (n > 1) begin
      send(d1, a);        chk("R3 ack second data byte", a, 1'b1);
    end
    bus_stop();
  endtask

  task automatic rd_ptr(input logic [7:0] ptr, input int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send({TGT, 1'b0}, a);
    send(ptr, a);
    bus_start();
    send({TGT, 1'b1}, a); chk("R3 ack address+R", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      rbuf[i] = b;
    end
    bus_stop();
  endtask

  task automatic rd_cont(input int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send({TGT, 1'b1}, a);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      rbuf[i] = b;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] exp_v [8];
    exp_v = '{8'h00, 8'h00, 8'h80, 8'h04, 8'h0C, 8'h7F, 8'hDC, 8'h41};
    chk("R1 flags at reset", flags, 8'h00);
    chk("R1 thresholds at reset", thr, 32'h0);
    chk("R1 sda released at reset", sda_oe, 1'b0);
    rd_ptr(8'h00, 8);
    for (int i = 0; i < 8; i++) chk("R1 R5 reset byte burst", rbuf[i], exp_v[i]);
  endtask

  task automatic t_address();
    logic a;
    wr_bytes(8'h01, 1, 8'h5A, 8'h00);
    chk("R4 strobe address", last_wa, 8'h01);
    chk("R4 strobe data", last_wd, 8'h5A);
    chk("R4 cfg output", cfg[15:8], 8'h5A);
    bus_start();
    send({7'h22, 1'b0}, a); chk("R2 foreign address not acked", a, 1'b0);
    send(8'h01, a);
    send(8'hFF, a);
    bus_stop();
    rd_ptr(8'h01, 1);
    chk("R2 foreign write had no effect", rbuf[0], 8'h5A);
  endtask

  task automatic t_pointer();
    wr_bytes(8'h00, 2, 8'h11, 8'h22);
    chk("R4 burst first byte", cfg[7:0], 8'h11);
    chk("R4 burst second byte", cfg[15:8], 8'h22);
    rd_ptr(8'h01, 1);
    chk("R5 read at pointer", rbuf[0], 8'h22);
    rd_cont(2);
    chk("R6 pointer kept after STOP", rbuf[0], 8'h80);
    chk("R6 continued burst", rbuf[1], 8'h04);
  endtask

  task automatic t_result();
    res[15:0]  = 16'h1234;
    res[31:16] = 16'h5678;
    rd_ptr(8'h10, 1);
    chk("R7 low byte live", rbuf[0], 8'h34);
    res[15:0] = 16'hABCD;
    rd_cont(1);
    chk("R7 high byte from capture", rbuf[0], 8'h12);
    rd_ptr(8'h12, 2);
    chk("R7 channel 1 low", rbuf[0], 8'h78);
    chk("R7 channel 1 high", rbuf[1], 8'h56);
  endtask

  task automatic t_threshold();
    wr_bytes(8'h08, 1, 8'h55, 8'h00);
    chk("R8 low byte alone commits nothing", thr, 32'h0);
    wr_bytes(8'h09, 1, 8'h66, 8'h00);
    chk("R8 both halves commit", thr[15:0], 16'h6655);
    wr_bytes(8'h0A, 2, 8'h01, 8'h02);
    chk("R8 burst commit", thr[31:16], 16'h0201);
    wr_bytes(8'h08, 1, 8'h77, 8'h00);
    wr_bytes(8'h0B, 1, 8'h88, 8'h00);
    chk("R9 held byte follows high write", thr[31:16], 16'h8877);
    chk("R9 other threshold untouched", thr[15:0], 16'h6655);
  endtask

  task automatic t_flags();
    @(negedge clk); flag_set = 8'hF0;
    @(negedge clk); flag_set = 8'h00;
    chk("R10 events set flags", flags, 8'hF0);
    wr_bytes(8'h0C, 1, 8'h30, 8'h00);
    chk("R10 write one to clear", flags, 8'hC0);
    fork
      wr_bytes(8'h0C, 1, 8'h80, 8'h00);
      begin
        do @(negedge clk); while (!(wr_stb && wr_addr == 8'h0C));
        flag_set = 8'h80;
        @(negedge clk);
        flag_set = 8'h00;
      end
    join
    chk("R10 event wins over same-cycle clear", flags, 8'hC0);
    rd_ptr(8'h0C, 1);
    chk("R11 read value", rbuf[0], 8'hC0);
    chk("R11 no clear when disabled", flags, 8'hC0);
    wr_bytes(8'h04, 1, 8'h8C, 8'h00);
    rd_ptr(8'h0C, 1);
    chk("R11 read returns flags before clear", rbuf[0], 8'hC0);
    chk("R11 read clears flags", flags, 8'h00);
  endtask

  task automatic t_readonly();
    wr_bytes(8'h06, 2, 8'h00, 8'h00);
    rd_ptr(8'h06, 2);
    chk("R12 identity A ignores write", rbuf[0], 8'hDC);
    chk("R12 identity B ignores write", rbuf[1], 8'h41);
    rd_ptr(8'h20, 2);
    chk("R12 unmapped reads zero", rbuf[0], 8'h00);
    chk("R12 unmapped reads zero next", rbuf[1], 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_address();
    t_pointer();
    t_result();
    t_threshold();
    t_flags();
    t_readonly();
    finish_run();
  end
endmodule